// File: doc/BRIEF.md
# ADC Serial Result Transmitter

This block is the serial read-out path of a 12-bit converter front end. It holds the last completed conversion result and sends it out one bit at a time on a single data line. Two clocking modes are available. With the internal clock, starting a new conversion also starts a burst of exactly twelve clock pulses that the block drives itself, and those pulses carry the result of the previous conversion while the new one is still running. With an external clock, a read access first produces a one-period framing pulse. Then, on each external clock cycle, one result bit is shifted out, followed by a stream of delayed tag bits.

The tag stream lets several converters share one data line in a chain. Each device forwards the tag input it saw twelve clock periods earlier, so the host collects all results back to back. The conversion controller reports its progress on the busy line. A busy rising edge copies the fresh result into the output holding register, unless the external clock is high at that moment. The whole block runs on one system clock. The external data clock and the tag input are sampled by that clock, so they must be much slower than it.

Top module: `adc_serial_tx`

## Requirements
- R1: After reset, the data enable, the framing output and the driven data clock are all low.
- R2: In internal mode, a convert command (chip select low and read/convert low while busy is high) produces exactly 12 high pulses on the driven data clock, with a period of 2*HALF system clocks. They carry the held result MSB first. Each bit changes at the same system clock edge on which the data clock rises. The data enable is high at every rise and low again after the last pulse, and the data clock stays low when idle.
- R3: A convert command issued while busy is low produces no clock pulses and no data.
- R4: Once an internal-mode burst has started, changes on read/convert do not alter it.
- R5: A busy rising edge copies the result input into the holding register. In external mode, if the sampled data clock is high at that edge, the copy is skipped and the older value is kept.
- R6: In external mode, a read access starts when chip select is low and read/convert is high and either of them has just changed. The framing output then goes high at the next data clock rise and stays high for one data clock period. The MSB appears at the following rise, and framing and data enable are never high together.
- R7: In external mode, after the 12 result bits, each further bit equals the tag input as sampled at the data clock fall 12 periods earlier. Two chained devices therefore deliver 24 result bits in order.
- R8: In external mode, ending the read access (chip select high or read/convert low) turns the data enable off at the next system clock edge. A new read access starts again with a framing pulse and the MSB.
- R9: The data clock output is enabled only in internal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_conv | input | 1 | High selects read, low selects convert |
| busy | input | 1 | Low while a conversion runs; a rising edge marks a completed result |
| result | input | DW | Conversion result from the controller |
| ext_mode | input | 1 | 1 selects the external data clock, 0 the internal one |
| dclk_i | input | 1 | External data clock |
| dclk_o | output | 1 | Internally generated data clock |
| dclk_oe | output | 1 | Drive enable for the data clock pin |
| sync_o | output | 1 | Framing pulse in external mode |
| tag_i | input | 1 | Chain input, forwarded after the result bits |
| sdata_o | output | 1 | Serial data value |
| sdata_oe | output | 1 | Serial data drive enable (low means high impedance) |

## Verification
In internal mode, each data bit shows up at the same system clock edge as the data clock rise it belongs to. The bench therefore watches every clock cycle, captures the bit whenever it first sees the clock high, and checks that rises are four cycles apart with the default divider. In external mode, a data clock edge reaches the output two system clock edges after the bench drives it. The bench holds each data clock level for four cycles and samples just before it drives the falling level, so each sample sits well after the update. A deselect is checked one cycle after it is driven, and the result of a busy edge is checked through the next full read.

// File: rtl/adc_stx_pkg.sv
// Package: shared types of the serial result transmitter.
// Assumes: nothing; it only holds the frame state encoding.
package adc_stx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no transfer, data line released
        ST_ARM  = 2'd1,   // read accepted, waiting for first external rise
        ST_SYNC = 2'd2,   // framing pulse is being driven
        ST_DATA = 2'd3    // result and tag bits are being sent
    } stx_state_e;
endpackage

// File: rtl/stx_clkgen.sv
// Module: internal data clock generator.
// Produces a data clock of 2*HALF system clocks per period while running and
// flags the cycle in which it rises or falls. Output is low whenever idle.
// Assumes: start and stop are single-cycle strobes, never both at once.
module stx_clkgen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic dclk,
    output logic rise,
    output logic fall
);
    localparam int DIVW = (HALF > 1) ? $clog2(HALF) : 1;

    logic            run_q;
    logic            dclk_q;
    logic [DIVW-1:0] div_q;
    logic            tick;

    // Half-period reached: the clock toggles at the coming edge.
    assign tick = run_q && (div_q == DIVW'(HALF - 1));
    assign rise = tick && !dclk_q;
    assign fall = tick && dclk_q;
    assign dclk = dclk_q;

    // Run flag, divider count and clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            dclk_q <= 1'b0;
            div_q  <= '0;
        end else if (start) begin
            run_q  <= 1'b1;
            dclk_q <= 1'b0;
            div_q  <= '0;
        end else if (stop) begin
            run_q  <= 1'b0;
            dclk_q <= 1'b0;
            div_q  <= '0;
        end else if (run_q) begin
            if (tick) begin
                div_q  <= '0;
                dclk_q <= !dclk_q;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    p_dclk_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> !dclk_q);
endmodule

// File: rtl/stx_ext_sampler.sv
// Module: external data clock and tag sampler.
// Registers the external clock and tag once and reports rising and falling
// edges one cycle later.
// Assumes: the external clock is much slower than the system clock and
// arrives already synchronous to it.
module stx_ext_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic dclk_i,
    input  logic tag_i,
    output logic dclk_hi,
    output logic rise,
    output logic fall,
    output logic tag_s
);
    logic d1_q, d2_q, tag_q;

    // Two-deep history of the clock, with the tag taken alongside.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d1_q  <= 1'b0;
            d2_q  <= 1'b0;
            tag_q <= 1'b0;
        end else begin
            d1_q  <= dclk_i;
            d2_q  <= d1_q;
            tag_q <= tag_i;
        end
    end

    assign dclk_hi = d1_q;
    assign rise    = d1_q && !d2_q;
    assign fall    = !d1_q && d2_q;
    assign tag_s   = tag_q;
endmodule

// File: rtl/stx_frame_ctl.sv
// Module: frame controller.
// Sequences one transfer: framing and open-ended data in external mode,
// a counted burst of DW pulses in internal mode. Issues the load, output
// and shift strobes for the data path.
// Assumes: ext_mode only changes while idle; rd_start is gated with
// ext_mode and cv_start with its inverse by the caller.
module stx_frame_ctl
    import adc_stx_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_mode,
    input  logic cv_start,
    input  logic rd_start,
    input  logic rd_lvl,
    input  logic rise,
    input  logic fall,
    output logic load,
    output logic out_stb,
    output logic shift_stb,
    output logic gen_start,
    output logic gen_stop,
    output logic sync_o,
    output logic sdata_oe
);
    localparam int CW = $clog2(DW + 1);

    stx_state_e     st_q;
    logic           sync_q;
    logic           oe_q;
    logic [CW-1:0]  cnt_q;
    logic           abort;

    // Strobes for the data path and the internal clock generator.
    always_comb begin
        abort     = ext_mode && (rd_start || !rd_lvl);
        out_stb   = rise && ((st_q == ST_SYNC) || (st_q == ST_DATA)) && !abort;
        shift_stb = fall && (st_q == ST_DATA) && !abort;
        gen_start = cv_start && (st_q == ST_IDLE);
        gen_stop  = !ext_mode && (st_q == ST_DATA) && fall && (cnt_q == CW'(DW));
        load      = rd_start || gen_start;
    end

    // Frame state, framing pulse, data enable and pulse count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            sync_q <= 1'b0;
            oe_q   <= 1'b0;
            cnt_q  <= '0;
        end else if (rd_start) begin
            st_q   <= ST_ARM;
            sync_q <= 1'b0;
            oe_q   <= 1'b0;
            cnt_q  <= '0;
        end else if (ext_mode && !rd_lvl) begin
            st_q   <= ST_IDLE;
            sync_q <= 1'b0;
            oe_q   <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (gen_start) begin
                        st_q  <= ST_DATA;
                        cnt_q <= '0;
                    end
                end
                ST_ARM: begin
                    if (rise) begin
                        st_q   <= ST_SYNC;
                        sync_q <= 1'b1;
                    end
                end
                ST_SYNC: begin
                    if (rise) begin
                        st_q   <= ST_DATA;
                        sync_q <= 1'b0;
                        oe_q   <= 1'b1;
                    end
                end
                ST_DATA: begin
                    if (!ext_mode) begin
                        if (rise) begin
                            oe_q  <= 1'b1;
                            cnt_q <= cnt_q + 1'b1;
                        end
                        if (gen_stop) begin
                            st_q  <= ST_IDLE;
                            oe_q  <= 1'b0;
                            cnt_q <= '0;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign sync_o   = sync_q;
    assign sdata_oe = oe_q;

    p_sync_data_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sync_q, oe_q}));
    p_sync_only_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q |-> ext_mode);
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DW));
    p_deselect_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && !rd_lvl) |=> !oe_q);
endmodule

// File: rtl/stx_shift.sv
// Module: result holding and output shift register.
// Captures a finished result on the busy rising edge, copies it into the
// shift register when a transfer starts, and shifts the tag in behind it.
// Assumes: load, out_stb and shift_stb are single-cycle strobes.
module stx_shift #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic [DW-1:0] result,
    input  logic          ext_mode,
    input  logic          dclk_hi,
    input  logic          load,
    input  logic          out_stb,
    input  logic          shift_stb,
    input  logic          tag_s,
    output logic          sdata
);
    logic          busy_q;
    logic [DW-1:0] hold_q;
    logic [DW-1:0] sr_q;
    logic          sd_q;
    logic          busy_rise;
    logic          lost;

    assign busy_rise = busy && !busy_q;
    assign lost      = ext_mode && dclk_hi;

    // Busy edge tracking and result capture, skipped while the clock is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b1;
            hold_q <= '0;
        end else begin
            busy_q <= busy;
            if (busy_rise && !lost)
                hold_q <= result;
        end
    end

    // Shift register: load at frame start, tag enters at each data fall.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '0;
        else if (load)
            sr_q <= hold_q;
        else if (shift_stb)
            sr_q <= {sr_q[DW-2:0], tag_s};
    end

    // Output bit: updated at each data clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sd_q <= 1'b0;
        else if (load)
            sd_q <= 1'b0;
        else if (out_stb)
            sd_q <= sr_q[DW-1];
    end

    assign sdata = sd_q;

    p_lost_keeps_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_rise && lost) |=> $stable(hold_q));
endmodule

// File: rtl/adc_serial_tx.sv
// Module: serial result transmitter, top level.
// Decodes convert and read commands, selects the clock source and joins the
// clock generator, external sampler, frame controller and shift register.
// Assumes: one system clock; external clock and tag slow and synchronous.
module adc_serial_tx #(
    parameter int DW   = 12,
    parameter int HALF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_conv,
    input  logic          busy,
    input  logic [DW-1:0] result,
    input  logic          ext_mode,
    input  logic          dclk_i,
    output logic          dclk_o,
    output logic          dclk_oe,
    output logic          sync_o,
    input  logic          tag_i,
    output logic          sdata_o,
    output logic          sdata_oe
);
    logic conv_lvl, rd_lvl, conv_q, rd_q;
    logic cv_start, rd_start;
    logic g_rise, g_fall, x_rise, x_fall, rise, fall;
    logic dclk_hi, tag_s;
    logic load, out_stb, shift_stb, gen_start, gen_stop;

    assign conv_lvl = !cs_n && !rd_conv;
    assign rd_lvl   = !cs_n && rd_conv;

    // Command level history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_q <= 1'b1;
            rd_q   <= 1'b1;
        end else begin
            conv_q <= conv_lvl;
            rd_q   <= rd_lvl;
        end
    end

    assign cv_start = conv_lvl && !conv_q && busy && !ext_mode;
    assign rd_start = rd_lvl && !rd_q && ext_mode;
    assign rise     = ext_mode ? x_rise : g_rise;
    assign fall     = ext_mode ? x_fall : g_fall;
    assign dclk_oe  = !ext_mode;

    stx_clkgen #(.HALF(HALF)) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .start (gen_start),
        .stop  (gen_stop),
        .dclk  (dclk_o),
        .rise  (g_rise),
        .fall  (g_fall)
    );

    stx_ext_sampler u_samp (
        .clk     (clk),
        .rst_n   (rst_n),
        .dclk_i  (dclk_i),
        .tag_i   (tag_i),
        .dclk_hi (dclk_hi),
        .rise    (x_rise),
        .fall    (x_fall),
        .tag_s   (tag_s)
    );

    stx_frame_ctl #(.DW(DW)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_mode  (ext_mode),
        .cv_start  (cv_start),
        .rd_start  (rd_start),
        .rd_lvl    (rd_lvl),
        .rise      (rise),
        .fall      (fall),
        .load      (load),
        .out_stb   (out_stb),
        .shift_stb (shift_stb),
        .gen_start (gen_start),
        .gen_stop  (gen_stop),
        .sync_o    (sync_o),
        .sdata_oe  (sdata_oe)
    );

    stx_shift #(.DW(DW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .result    (result),
        .ext_mode  (ext_mode),
        .dclk_hi   (dclk_hi),
        .load      (load),
        .out_stb   (out_stb),
        .shift_stb (shift_stb),
        .tag_s     (tag_s),
        .sdata     (sdata_o)
    );

    p_busy_blocks_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !gen_start);
endmodule

// File: tb/sim_adc_serial_tx.sv
module sim_adc_serial_tx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, rd_conv = 1'b1, busy = 1'b1, ext_mode = 1'b0;
    logic dclk_i = 1'b0, tag_in = 1'b0;
    logic [11:0] res0 = '0, res1 = '0;
    logic dclk0, dclk_oe0, sync0, sd0, oe0;
    logic dclk1, dclk_oe1, sync1, sd1, oe1;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = !clk;

    // u0 is the device the host reads; u1 feeds its tag input.
    adc_serial_tx u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_conv(rd_conv),
        .busy(busy), .result(res0), .ext_mode(ext_mode), .dclk_i(dclk_i),
        .dclk_o(dclk0), .dclk_oe(dclk_oe0), .sync_o(sync0), .tag_i(sd1),
        .sdata_o(sd0), .sdata_oe(oe0));
    adc_serial_tx u1 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_conv(rd_conv),
        .busy(busy), .result(res1), .ext_mode(ext_mode), .dclk_i(dclk_i),
        .dclk_o(dclk1), .dclk_oe(dclk_oe1), .sync_o(sync1), .tag_i(tag_in),
        .sdata_o(sd1), .sdata_oe(oe1));

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    task automatic pulse_busy(input logic [11:0] a, input logic [11:0] b);
        @(negedge clk);
        busy = 1'b0; res0 = a; res1 = b;
        repeat (2) @(negedge clk);
        busy = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // One external data clock period; samples u0 just before the fall.
    task automatic ext_tick(output logic s, output logic o, output logic d);
        dclk_i = 1'b1;
        repeat (4) @(negedge clk);
        s = sync0; o = oe0; d = sd0;
        dclk_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic read_word(output logic [11:0] w, output logic sync_ok);
        logic s, o, d;
        w = '0;
        @(negedge clk); cs_n = 1'b0; rd_conv = 1'b1;
        repeat (3) @(negedge clk);
        ext_tick(s, o, d);
        sync_ok = s && !o;
        for (int k = 0; k < 12; k++) begin
            ext_tick(s, o, d);
            w[11-k] = d;
        end
        @(negedge clk); cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!oe0, "R1 data enable after reset", oe0, 0);
        chk(!sync0, "R1 framing after reset", sync0, 0);
        chk(!dclk0, "R1 data clock after reset", dclk0, 0);
        chk(dclk_oe0, "R9 clock driven in internal mode", dclk_oe0, 1);
    endtask

    // Internal burst: expects word exp, loads nxt during the conversion.
    task automatic t_internal(input logic [11:0] exp, input logic [11:0] nxt);
        int rises = 0, last = -1, gap_bad = 0, oe_bad = 0;
        logic prev;
        logic [11:0] got = '0;
        @(negedge clk); cs_n = 1'b0; rd_conv = 1'b0;
        prev = dclk0;
        for (int c = 0; c < 70; c++) begin
            @(negedge clk);
            if (dclk0 && !prev) begin
                if (rises < 12) got[11-rises] = sd0;
                if (!oe0) oe_bad++;
                if (last >= 0 && (c - last) != 4) gap_bad++;
                last = c;
                rises++;
            end
            prev = dclk0;
            if (c == 1) begin busy = 1'b0; res0 = nxt; res1 = ~nxt; end
            if (c == 20) rd_conv = 1'b1;   // R4: read/convert rises mid-burst
        end
        chk(rises == 12, "R2 pulse count", rises, 12);
        chk(gap_bad == 0, "R2 pulse period", gap_bad, 0);
        chk(oe_bad == 0, "R2 enable at each rise", oe_bad, 0);
        chk(got == exp, "R2/R4 burst data", got, exp);
        chk(!oe0 && !dclk0, "R2 idle after burst", {oe0, dclk0}, 0);
        busy = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_busy_ignore(input logic [11:0] nxt);
        int rises = 0, oe_seen = 0;
        logic prev;
        @(negedge clk); busy = 1'b0; res0 = nxt;
        @(negedge clk); cs_n = 1'b0; rd_conv = 1'b0;
        prev = dclk0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (dclk0 && !prev) rises++;
            if (oe0) oe_seen++;
            prev = dclk0;
        end
        chk(rises == 0, "R3 pulses while busy low", rises, 0);
        chk(oe_seen == 0, "R3 data while busy low", oe_seen, 0);
        rd_conv = 1'b1;
        @(negedge clk); busy = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_daisy(input logic [11:0] a, input logic [11:0] b);
        logic s, o, d;
        int bad = 0;
        pulse_busy(a, b);
        chk(!dclk_oe0, "R9 clock released in external mode", dclk_oe0, 0);
        @(negedge clk); cs_n = 1'b0; rd_conv = 1'b1;
        repeat (3) @(negedge clk);
        for (int k = 1; k <= 28; k++) begin
            ext_tick(s, o, d);
            if (k == 1) begin
                chk(s && !o, "R6 framing pulse first", {s, o}, 2);
            end else begin
                if (k == 2) chk(!s && o, "R6 framing lasts one period", {s, o}, 1);
                if (k <= 13) begin
                    if (d !== a[13-k]) bad++;
                end else if (k <= 25) begin
                    if (d !== b[25-k]) bad++;
                end else begin
                    chk(d === 1'b1, "R7 chained tag level", d, 1);
                end
            end
        end
        chk(bad == 0, "R7 daisy chain 24 bits in order", bad, 0);
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
        chk(!oe0, "R8 released after deselect", oe0, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_restart(input logic [11:0] a);
        logic s, o, d;
        @(negedge clk); cs_n = 1'b0; rd_conv = 1'b1;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 5; k++) ext_tick(s, o, d);
        rd_conv = 1'b0;
        @(negedge clk);
        chk(!oe0, "R8 released when read/convert low", oe0, 0);
        rd_conv = 1'b1;
        repeat (2) @(negedge clk);
        ext_tick(s, o, d);
        chk(s && !o, "R8 restart framing", {s, o}, 2);
        ext_tick(s, o, d);
        chk(o && d === a[11], "R8 restart from MSB", {o, d}, {1'b1, a[11]});
        @(negedge clk); cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_loss(input logic [11:0] old_w, input logic [11:0] new_w);
        logic [11:0] w;
        logic sok;
        @(negedge clk); dclk_i = 1'b1;
        repeat (3) @(negedge clk);
        pulse_busy(new_w, new_w);
        dclk_i = 1'b0;
        repeat (3) @(negedge clk);
        read_word(w, sok);
        chk(w == old_w, "R5 capture lost with clock high", w, old_w);
        chk(sok, "R6 framing on plain read", sok, 1);
        pulse_busy(new_w, new_w);
        read_word(w, sok);
        chk(w == new_w, "R5 capture with clock low", w, new_w);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        pulse_busy(12'hB3A, 12'h111);
        t_internal(12'hB3A, 12'h4C7);
        t_internal(12'h4C7, 12'h9E2);
        t_internal(12'h9E2, 12'h9E2);
        t_busy_ignore(12'h1F0);
        @(negedge clk); cs_n = 1'b1;
        repeat (2) @(negedge clk);
        t_internal(12'h1F0, 12'h1F0);
        @(negedge clk); cs_n = 1'b1; rd_conv = 1'b1; ext_mode = 1'b1; tag_in = 1'b1;
        repeat (3) @(negedge clk);
        t_daisy(12'hA5C, 12'h3E1);
        t_restart(12'hA5C);
        t_loss(12'hA5C, 12'h6D3);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule